// File: doc/BRIEF.md
# Link Transmitter Parity Error Monitor

This block sits at the sending end of a serial handshake link. Parity is not checked here. The receiver signals a parity error by holding its ready line low for longer than usual. After each frame the monitor opens a response window of programmable length and watches the ready line. If ready is seen high inside the window, the frame is taken as delivered correctly. If ready is still low when the window closes, a transmitter parity error condition is inferred.

Each inferred error sets a flag that describes the latest frame. It also draws down an error budget held in a down-counter. When the budget runs out, the block emits a one-cycle error event and sets a sticky interrupt status bit. After that, every further error raises the event again until software reloads the budget. A budget of 0 therefore reports every error as an event. All pins are plain control and status lines. No data moves through the block, so it has no valid/ready stream and exerts no back-pressure.

Top module: `ptx_perr_mon`

## Requirements
- R1: After reset, `perr_flag`, `perr_event` and `perr_irq` are 0, and `budget` equals the parameter `RST_BUDGET` (default 0).
- R2: After a clock edge that samples `frame_sent` high, `rdy_in` is sampled on the next `dly_limit`+1 edges. At the first of these edges that sees `rdy_in` = 1 the window closes as good. At that edge `perr_flag` clears and `budget` is left unchanged.
- R3: If `rdy_in` is 0 on all `dly_limit`+1 window edges, an error condition is declared on the last of them. At that edge `perr_flag` becomes 1 and `budget` decrements by one. `budget` saturates at 0.
- R4: An error condition declared while `budget` is 1 or 0 makes `perr_event` 1 for exactly one cycle. An error condition declared while `budget` is 2 or more leaves `perr_event` at 0.
- R5: `perr_irq` is set by every event and holds until the clock edge that samples `clr_irq` = 1. If both happen on the same edge, the set wins.
- R6: `clr_flag` = 1 clears `perr_flag` on the next edge. If an error is declared on the same edge, the flag is set instead.
- R7: `wr_budget` = 1 loads `budget_wdata` into `budget` on the next edge. The load wins over a decrement on the same edge. The event is still decided from the old budget.
- R8: When `frame_sent` is sampled high while a window is open, the window restarts from its first edge, and `rdy_in` is not judged on that edge. While no window is open, `rdy_in` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sent | input | 1 | One-cycle strobe at the end of a frame's parity bit |
| rdy_in | input | 1 | Ready line returned by the receiver |
| dly_limit | input | DLY_W | Window length minus one, in clock cycles |
| wr_budget | input | 1 | Load strobe for the error budget |
| budget_wdata | input | CNT_W | Value to load into the budget |
| clr_flag | input | 1 | Write-1 clear of the error flag |
| clr_irq | input | 1 | Write-1 clear of the sticky status bit |
| perr_flag | output | 1 | Error state of the latest frame |
| budget | output | CNT_W | Remaining error budget |
| perr_event | output | 1 | One-cycle error event pulse |
| perr_irq | output | 1 | Sticky error status bit |

## Verification
Let E0 be the edge that samples the frame strobe. The verdict then falls on edge E0+k, where k is the first window edge that sees ready high, or on edge E0+`dly_limit`+1 when ready never rises. Flag, budget, event and status all change on that same edge, because the window decision is combinational into their registers. Register writes take effect on the edge that samples them. The bench drives and samples on falling edges. At the falling edge just before the deadline it checks that nothing has changed yet. At the falling edge just after the deadline it checks that the results are present. It checks the event again one cycle later to confirm it is a single-cycle pulse.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic {WIN_IDLE = 1'b0, WIN_OPEN = 1'b1} win_state_e;
endpackage

// File: rtl/ptx_window.sv
module ptx_window
  import ptx_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rdy_in,
  input  logic [DLY_W-1:0] limit,
  output logic             good,
  output logic             miss
);
  win_state_e       state;
  logic [DLY_W-1:0] elapsed;
  logic             judging;
  logic             at_end;

  // A restart strobe pre-empts judging in the same cycle
  assign judging = (state == WIN_OPEN) && !start;
  assign at_end  = (elapsed == limit);
  assign good    = judging && rdy_in;
  assign miss    = judging && !rdy_in && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= WIN_IDLE;
      elapsed <= '0;
    end else if (start) begin
      state   <= WIN_OPEN;
      elapsed <= '0;
    end else if (judging) begin
      if (rdy_in || at_end) state <= WIN_IDLE;
      else                  elapsed <= elapsed + 1'b1;
    end
  end
endmodule

// File: rtl/ptx_budget.sv
module ptx_budget #(
  parameter int              CNT_W      = 4,
  parameter logic [CNT_W-1:0] RST_BUDGET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic             exhaust
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic last_err;

  // Budget becoming zero or already zero
  assign last_err = miss && (count <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= RST_BUDGET;
      exhaust <= 1'b0;
    end else begin
      exhaust <= last_err;
      if (wr)                        count <= wdata;
      else if (miss && count != '0)  count <= count - ONE;
    end
  end
endmodule

// File: rtl/ptx_status.sv
module ptx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic miss,
  input  logic good,
  input  logic raise,
  input  logic clr_flag,
  input  logic clr_irq,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (miss)                  flag <= 1'b1;
      else if (good || clr_flag) flag <= 1'b0;
      if (raise)                 irq <= 1'b1;
      else if (clr_irq)          irq <= 1'b0;
    end
  end
endmodule

// File: rtl/ptx_perr_mon.sv
module ptx_perr_mon #(
  parameter int               DLY_W      = 4,
  parameter int               CNT_W      = 4,
  parameter logic [CNT_W-1:0] RST_BUDGET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sent,
  input  logic             rdy_in,
  input  logic [DLY_W-1:0] dly_limit,
  input  logic             wr_budget,
  input  logic [CNT_W-1:0] budget_wdata,
  input  logic             clr_flag,
  input  logic             clr_irq,
  output logic             perr_flag,
  output logic [CNT_W-1:0] budget,
  output logic             perr_event,
  output logic             perr_irq
);
  logic win_good;
  logic win_miss;
  logic last_err;

  ptx_window #(.DLY_W(DLY_W)) u_window (
    .clk(clk), .rst_n(rst_n), .start(frame_sent), .rdy_in(rdy_in),
    .limit(dly_limit), .good(win_good), .miss(win_miss)
  );

  ptx_budget #(.CNT_W(CNT_W), .RST_BUDGET(RST_BUDGET)) u_budget (
    .clk(clk), .rst_n(rst_n), .miss(win_miss), .wr(wr_budget),
    .wdata(budget_wdata), .count(budget), .exhaust(perr_event)
  );

  // Sticky bit is set on the same edge as the event register
  assign last_err = win_miss && (budget <= CNT_W'(1));

  ptx_status u_status (
    .clk(clk), .rst_n(rst_n), .miss(win_miss), .good(win_good),
    .raise(last_err), .clr_flag(clr_flag), .clr_irq(clr_irq),
    .flag(perr_flag), .irq(perr_irq)
  );
endmodule

// File: rtl/ptx_perr_mon_chk.sv
module ptx_perr_mon_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_budget,
  input logic             clr_irq,
  input logic [CNT_W-1:0] budget,
  input logic             perr_event,
  input logic             perr_flag,
  input logic             perr_irq
);
  p_event_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    perr_event |=> !perr_event);

  p_event_sets_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    perr_event |-> perr_irq);

  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_irq && !clr_irq) |=> perr_irq);

  p_event_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    perr_event |-> perr_flag);

  p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (budget == '0 && !wr_budget) |=> budget == '0);

  p_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_budget |=> budget <= $past(budget));
endmodule

bind ptx_perr_mon ptx_perr_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_budget(wr_budget), .clr_irq(clr_irq),
  .budget(budget), .perr_event(perr_event), .perr_flag(perr_flag),
  .perr_irq(perr_irq)
);

// File: tb/tb_ptx_perr_mon.sv
module tb_ptx_perr_mon;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W = 4;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sent = 1'b0, rdy_in = 1'b0, wr_budget = 1'b0;
  logic clr_flag = 1'b0, clr_irq = 1'b0;
  logic [DLY_W-1:0] dly_limit = 4'd2;
  logic [CNT_W-1:0] budget_wdata = '0;
  logic perr_flag, perr_event, perr_irq;
  logic [CNT_W-1:0] budget;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ptx_perr_mon #(.DLY_W(DLY_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .frame_sent(frame_sent), .rdy_in(rdy_in),
    .dly_limit(dly_limit), .wr_budget(wr_budget), .budget_wdata(budget_wdata),
    .clr_flag(clr_flag), .clr_irq(clr_irq), .perr_flag(perr_flag),
    .budget(budget), .perr_event(perr_event), .perr_irq(perr_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, int f, int b, int e, int i);
    chk({req, " flag"}, int'(perr_flag), f);
    chk({req, " budget"}, int'(budget), b);
    chk({req, " event"}, int'(perr_event), e);
    chk({req, " irq"}, int'(perr_irq), i);
  endtask

  // Frame strobe, then L window edges with ready low; caller finishes
  task automatic frame_upto_last();
    frame_sent = 1'b1; tick(); frame_sent = 1'b0;
    for (int k = 0; k < int'(dly_limit); k++) tick();
  endtask

  task automatic write_budget(int v);
    wr_budget = 1'b1; budget_wdata = CNT_W'(v); tick(); wr_budget = 1'b0;
  endtask

  task automatic t_reset();
    chk_all("R1 reset", 0, 0, 0, 0);
  endtask

  task automatic t_load();
    write_budget(3);
    chk("R7 load", int'(budget), 3);
  endtask

  task automatic t_miss_dec();
    frame_upto_last();
    chk_all("R3 before deadline", 0, 3, 0, 0);
    tick();
    chk_all("R3 at deadline", 1, 2, 0, 0);
  endtask

  task automatic t_good_late();
    frame_upto_last();
    rdy_in = 1'b1; tick(); rdy_in = 1'b0;
    chk_all("R2 ready on last edge", 0, 2, 0, 0);
  endtask

  task automatic t_early_then_exhaust();
    frame_upto_last(); tick();
    chk_all("R4 no event above one", 1, 1, 0, 0);
    frame_sent = 1'b1; tick(); frame_sent = 1'b0;
    rdy_in = 1'b1; tick(); rdy_in = 1'b0;
    chk_all("R2 ready on first edge", 0, 1, 0, 0);
    frame_upto_last(); tick();
    chk_all("R4 event on reaching zero", 1, 0, 1, 1);
    tick();
    chk_all("R4 pulse ends", 1, 0, 0, 1);
    frame_upto_last(); tick();
    chk_all("R4 event at zero, R3 saturate", 1, 0, 1, 1);
  endtask

  task automatic t_clear();
    clr_flag = 1'b1; clr_irq = 1'b1; tick(); clr_flag = 1'b0; clr_irq = 1'b0;
    chk("R6 clear flag", int'(perr_flag), 0);
    chk("R5 clear irq", int'(perr_irq), 0);
  endtask

  task automatic t_priority();
    frame_upto_last();
    clr_flag = 1'b1; clr_irq = 1'b1; wr_budget = 1'b1; budget_wdata = 4'd5;
    tick();
    clr_flag = 1'b0; clr_irq = 1'b0; wr_budget = 1'b0;
    chk("R6 set beats clear", int'(perr_flag), 1);
    chk("R5 set beats clear", int'(perr_irq), 1);
    chk("R7 load beats decrement", int'(budget), 5);
    chk("R7 event from old budget", int'(perr_event), 1);
    clr_flag = 1'b1; clr_irq = 1'b1; tick(); clr_flag = 1'b0; clr_irq = 1'b0;
  endtask

  task automatic t_restart();
    frame_sent = 1'b1; tick(); frame_sent = 1'b0;   // E0
    tick();                                        // E1
    frame_sent = 1'b1; tick(); frame_sent = 1'b0;   // E2 restarts
    tick();                                        // E3 old deadline
    chk_all("R8 old deadline ignored", 0, 5, 0, 0);
    tick();                                        // E4
    chk("R8 before new deadline", int'(perr_flag), 0);
    tick();                                        // E5
    chk_all("R8 new deadline", 1, 4, 0, 0);
  endtask

  task automatic t_idle_ready();
    rdy_in = 1'b1; tick(); tick(); rdy_in = 1'b0; tick();
    chk_all("R8 idle ready ignored", 1, 4, 0, 0);
  endtask

  task automatic t_limit_zero();
    dly_limit = '0;
    frame_sent = 1'b1; tick(); frame_sent = 1'b0;
    tick();
    chk_all("R3 zero limit one edge", 1, 3, 0, 0);
    write_budget(1);
    frame_sent = 1'b1; tick(); frame_sent = 1'b0; tick();
    chk_all("R4 budget one gives event", 1, 0, 1, 1);
    dly_limit = 4'd2;
  endtask

  initial begin
    repeat (2) tick();
    t_reset();
    rst_n = 1'b1; tick();
    t_load();
    t_miss_dec();
    t_good_late();
    t_early_then_exhaust();
    t_clear();
    t_priority();
    t_restart();
    t_idle_ready();
    t_limit_zero();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule